// File: doc/BRIEF.md
# Peak-current PWM cycle controller

This block produces the gate-drive pulse for a low-side power switch in a fixed-frequency, peak-current-mode converter. It runs on a fast system clock. A period counter creates an internal phase signal. Each switching cycle opens when that phase signal falls, and the drive stays high until one of two things happens. Either a comparator trip input reports that the sensed current has reached the error level, or the phase signal rises again, which ends the pulse at maximum duty. The analog side (error amplifier, slope ramp, comparator) lies outside the block and is seen only through the single trip input.

Right after each turn-on, the trip input is blanked for a short window so that leading-edge spikes do not cut the pulse short. An enable input is qualified with two different delays: a long one before switching starts and a shorter one before shutdown. While the block is shut down it asserts a soft-start reset strobe. An undervoltage flag actively holds the drive low. An overtemperature flag releases the output enable so the pin floats. A select bit chooses between two switching frequencies. All delays are computed from the system clock frequency, and the trip, enable and fault inputs pass through two-flop synchronizers.

Top module: `pcm_pwm_ctrl`

## Requirements
- R1: After reset, pwmDrive is 0, pwmOe is 1 and ssReset is 1.
- R2: With no trip, each cycle begins when the period counter wraps. The drive is high for PER - PH - 1 clocks and low for the rest of the period. PH = PER*(100-85)/100 is the phase-high time, during which the drive is always low.
- R3: A trip asserted after the blanking window drives pwmDrive low within 4 clocks. The drive stays low until the next cycle begins, even if the trip clears.
- R4: With freqSel = 0 the period is CLK_HZ/300 kHz (666 clocks at 200 MHz). With freqSel = 1 it is CLK_HZ/600 kHz (333 clocks). A change of freqSel takes effect at a period boundary.
- R5: The trip input is ignored for BLANK = 20 clocks (100 ns) after each turn-on. A trip that is held high from the turn-on onward gives a pulse of exactly BLANK + 1 clocks. A trip that clears inside the window leaves the full-width pulse.
- R6: If the trip is already asserted at the moment a cycle begins, the off request wins and that cycle produces no pulse.
- R7: Enable must stay low for 50 µs (10000 clocks) before shutdown. Shorter lows have no effect. In shutdown pwmDrive is 0 and ssReset is 1.
- R8: After enable goes high, switching resumes and ssReset falls only once 190 µs (38000 clocks) have passed. Until then pwmDrive stays 0.
- R9: While the undervoltage flag is high, pwmDrive is 0 within 4 clocks. A pulse that was cut short does not resume until the next cycle begins.
- R10: While the overtemperature flag is high, pwmOe is 0 within 4 clocks. It returns to 1 after the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tripIn | input | 1 | Comparator trip: sensed current has reached the error level |
| enIn | input | 1 | Enable request, qualified by delay |
| uvFlag | input | 1 | Undervoltage flag |
| otFlag | input | 1 | Overtemperature flag |
| freqSel | input | 1 | 0 selects the low switching frequency, 1 the high one |
| pwmDrive | output | 1 | Gate-drive level |
| pwmOe | output | 1 | Drive output enable; low means high-impedance |
| ssReset | output | 1 | Soft-start reset, high while shut down |

## Verification
The assertions assume two things. First, freqSel is a static strap, or changes only well away from a period wrap. Second, the asynchronous inputs stay stable for at least two clocks, so that each level reaches the latch through the synchronizers. The stimulus changes every input on the falling clock edge and holds each level for many clocks. Trip is raised only at known offsets from a measured turn-on, so the blanking and off-wins cases fall on exact cycles. Enable glitches are kept far shorter than the shutdown delay, and qualifications are observed with margins of 20 clocks on either side.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  // datapath -> control status
  typedef struct packed {
    logic phaseHigh;
    logic cycleStart;
    logic blankAct;
    logic qualDone;
    logic tripS;
    logic enS;
    logic uvS;
    logic otS;
  } dpStat_t;

  // control -> datapath strobes
  typedef struct packed {
    logic blankLoad;
    logic runLvl;
  } ctlStrobe_t;
endpackage

// File: rtl/pcm_datapath.sv
module pcm_datapath
  import pcm_pkg::*;
#(
  parameter int CLK_HZ       = 200_000_000,
  parameter int F_LO_HZ      = 300_000,
  parameter int F_HI_HZ      = 600_000,
  parameter int MAX_DUTY_PCT = 85,
  parameter int BLANK_NS     = 100,
  parameter int EN_OFF_US    = 50,
  parameter int EN_ON_US     = 190
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tripIn,
  input  logic       enIn,
  input  logic       uvFlag,
  input  logic       otFlag,
  input  logic       freqSel,
  input  ctlStrobe_t strb,
  output dpStat_t    stat
);
  localparam int PER_LO    = CLK_HZ / F_LO_HZ;
  localparam int PER_HI    = CLK_HZ / F_HI_HZ;
  localparam int PH_LO     = PER_LO * (100 - MAX_DUTY_PCT) / 100;
  localparam int PH_HI     = PER_HI * (100 - MAX_DUTY_PCT) / 100;
  localparam int CLK_MHZ   = CLK_HZ / 1_000_000;
  localparam int BLANK_CYC = CLK_MHZ * BLANK_NS / 1000;
  localparam int OFF_CYC   = CLK_MHZ * EN_OFF_US;
  localparam int ON_CYC    = CLK_MHZ * EN_ON_US;
  localparam int QMAX      = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
  localparam int CW        = $clog2(PER_LO + 1);
  localparam int BW        = $clog2(BLANK_CYC + 1);
  localparam int QW        = $clog2(QMAX + 1);
  localparam logic [CW-1:0] PER_LO_M1 = CW'(PER_LO - 1);
  localparam logic [CW-1:0] PER_HI_M1 = CW'(PER_HI - 1);
  localparam logic [CW-1:0] ON_LO     = CW'(PER_LO - PH_LO);
  localparam logic [CW-1:0] ON_HI     = CW'(PER_HI - PH_HI);
  localparam logic [BW-1:0] BLANK_W   = BW'(BLANK_CYC);
  localparam logic [QW-1:0] OFF_M1    = QW'(OFF_CYC - 1);
  localparam logic [QW-1:0] ON_M1     = QW'(ON_CYC - 1);
  localparam int NSYNC = 4;

  // two-flop synchronizers
  logic [NSYNC-1:0] rawIn, syncA, syncB;
  assign rawIn = {otFlag, uvFlag, enIn, tripIn};

  genvar gi;
  generate
    for (gi = 0; gi < NSYNC; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA[gi] <= 1'b0;
          syncB[gi] <= 1'b0;
        end else begin
          syncA[gi] <= rawIn[gi];
          syncB[gi] <= syncA[gi];
        end
      end
    end
  endgenerate

  // period counter, frequency choice latched at wrap
  logic [CW-1:0] cnt, lastCnt, onLen;
  logic          hiSel;
  assign lastCnt = hiSel ? PER_HI_M1 : PER_LO_M1;
  assign onLen   = hiSel ? ON_HI : ON_LO;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      hiSel <= 1'b0;
    end else if (cnt == lastCnt) begin
      cnt   <= '0;
      hiSel <= freqSel;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastCnt);  // R4

  // leading-edge blanking timer
  logic [BW-1:0] blankCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               blankCnt <= '0;
    else if (strb.blankLoad) blankCnt <= BLANK_W;
    else if (blankCnt != 0)  blankCnt <= blankCnt - 1'b1;
  end

  AST_BLANK_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    strb.blankLoad |=> (blankCnt == BLANK_W));  // R5

  // enable qualification counter, target depends on current run state
  logic [QW-1:0] qualCnt;
  logic          mismatch;
  assign mismatch = (syncB[1] != strb.runLvl);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          qualCnt <= '0;
    else if (!mismatch) qualCnt <= '0;
    else                qualCnt <= qualCnt + 1'b1;
  end

  assign stat.phaseHigh  = (cnt >= onLen);
  assign stat.cycleStart = (cnt == '0);
  assign stat.blankAct   = (blankCnt != '0);
  assign stat.qualDone   = mismatch && (qualCnt == (strb.runLvl ? OFF_M1 : ON_M1));
  assign stat.tripS      = syncB[0];
  assign stat.enS        = syncB[1];
  assign stat.uvS        = syncB[2];
  assign stat.otS        = syncB[3];
endmodule

// File: rtl/pcm_control.sv
module pcm_control
  import pcm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStat_t    stat,
  output ctlStrobe_t strb,
  output logic       pwmDrive,
  output logic       pwmOe,
  output logic       ssReset
);
  logic run, onQ, setReq, offReq, tripQual;

  assign tripQual = stat.tripS & ~stat.blankAct;
  assign setReq   = stat.cycleStart & run & ~stat.uvS;
  assign offReq   = stat.phaseHigh | tripQual | stat.uvS | ~run;

  // cycle latch: off request dominates, neither request holds
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) onQ <= 1'b0;
    else       onQ <= (onQ | setReq) & ~offReq;
  end

  // run state toggles when the qualification counter completes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              run <= 1'b0;
    else if (stat.qualDone) run <= ~run;
  end

  assign strb.blankLoad = setReq & ~offReq;
  assign strb.runLvl    = run;

  assign pwmDrive = onQ & ~stat.phaseHigh & ~stat.uvS;
  assign pwmOe    = ~stat.otS;
  assign ssReset  = ~run;

  AST_NO_MIDCYCLE_ON: assert property (@(posedge clk) disable iff (!rstN)
    (!onQ && !stat.cycleStart) |=> !onQ);  // R3
  AST_PHASE_ENDS_ON: assert property (@(posedge clk) disable iff (!rstN)
    stat.phaseHigh |=> !onQ);  // R2
  AST_BLANK_HOLDS_ON: assert property (@(posedge clk) disable iff (!rstN)
    (onQ && stat.blankAct && !stat.phaseHigh && !stat.uvS && run) |=> onQ);  // R5
  AST_TRIP_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    (stat.cycleStart && stat.tripS && !stat.blankAct) |=> !onQ);  // R6
  AST_SHUTDOWN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !onQ);  // R7
  AST_UV_OFF: assert property (@(posedge clk) disable iff (!rstN)
    stat.uvS |=> !onQ);  // R9
endmodule

// File: rtl/pcm_pwm_ctrl.sv
module pcm_pwm_ctrl
  import pcm_pkg::*;
#(
  parameter int CLK_HZ       = 200_000_000,
  parameter int F_LO_HZ      = 300_000,
  parameter int F_HI_HZ      = 600_000,
  parameter int MAX_DUTY_PCT = 85,
  parameter int BLANK_NS     = 100,
  parameter int EN_OFF_US    = 50,
  parameter int EN_ON_US     = 190
) (
  input  logic clk,
  input  logic rstN,
  input  logic tripIn,
  input  logic enIn,
  input  logic uvFlag,
  input  logic otFlag,
  input  logic freqSel,
  output logic pwmDrive,
  output logic pwmOe,
  output logic ssReset
);
  dpStat_t    stat;
  ctlStrobe_t strb;

  pcm_datapath #(
    .CLK_HZ(CLK_HZ), .F_LO_HZ(F_LO_HZ), .F_HI_HZ(F_HI_HZ),
    .MAX_DUTY_PCT(MAX_DUTY_PCT), .BLANK_NS(BLANK_NS),
    .EN_OFF_US(EN_OFF_US), .EN_ON_US(EN_ON_US)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tripIn(tripIn), .enIn(enIn),
    .uvFlag(uvFlag), .otFlag(otFlag), .freqSel(freqSel),
    .strb(strb), .stat(stat)
  );

  pcm_control u_ctl (
    .clk(clk), .rstN(rstN), .stat(stat), .strb(strb),
    .pwmDrive(pwmDrive), .pwmOe(pwmOe), .ssReset(ssReset)
  );
endmodule

// File: tb/pcm_pwm_ctrl_tb.sv
module pcm_pwm_ctrl_tb;
  localparam int PER_LO = 200_000_000 / 300_000;
  localparam int PER_HI = 200_000_000 / 600_000;
  localparam int W_LO   = PER_LO - PER_LO * 15 / 100 - 1;
  localparam int W_HI   = PER_HI - PER_HI * 15 / 100 - 1;
  localparam int BLANK  = 20;
  localparam int EN_ON  = 38000;
  localparam int EN_OFF = 10000;

  logic clk = 1'b0;
  logic rstN, tripIn, enIn, uvFlag, otFlag, freqSel;
  logic pwmDrive, pwmOe, ssReset;
  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  pcm_pwm_ctrl u_dut (
    .clk(clk), .rstN(rstN), .tripIn(tripIn), .enIn(enIn),
    .uvFlag(uvFlag), .otFlag(otFlag), .freqSel(freqSel),
    .pwmDrive(pwmDrive), .pwmOe(pwmOe), .ssReset(ssReset)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitRise();
    do @(negedge clk); while (pwmDrive !== 1'b0);
    do @(negedge clk); while (pwmDrive !== 1'b1);
  endtask

  task automatic measureWidth(output int w);
    w = 1;
    @(negedge clk);
    while (pwmDrive === 1'b1) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0; tripIn = 1'b0; enIn = 1'b0; uvFlag = 1'b0; otFlag = 1'b0; freqSel = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(pwmDrive === 1'b0, "R1 drive", int'(pwmDrive), 0);
    check(pwmOe === 1'b1, "R1 oe", int'(pwmOe), 1);
    check(ssReset === 1'b1, "R1 ssReset", int'(ssReset), 1);
  endtask

  task automatic t_startup();
    int highs = 0;
    enIn = 1'b1;
    for (int i = 0; i < EN_ON - 20; i++) begin
      @(negedge clk);
      if (pwmDrive === 1'b1) highs++;
    end
    check(ssReset === 1'b1, "R8 ssReset before qualify", int'(ssReset), 1);
    check(highs == 0, "R8 no drive before qualify", highs, 0);
    repeat (40) @(negedge clk);
    check(ssReset === 1'b0, "R8 ssReset after qualify", int'(ssReset), 0);
  endtask

  task automatic t_maxDuty();
    int w, p;
    waitRise();
    measureWidth(w);
    check(w == W_LO, "R2 max width", w, W_LO);
    p = w;
    do begin @(negedge clk); p++; end while (pwmDrive !== 1'b1);
    check(p == PER_LO, "R4 low period", p, PER_LO);
  endtask

  task automatic t_tripMid();
    waitRise();
    repeat (100) @(negedge clk);
    tripIn = 1'b1;
    repeat (4) @(negedge clk);
    check(pwmDrive === 1'b0, "R3 trip ends pulse", int'(pwmDrive), 0);
    tripIn = 1'b0;
    repeat (50) @(negedge clk);
    check(pwmDrive === 1'b0, "R3 stays off after trip clears", int'(pwmDrive), 0);
  endtask

  task automatic t_blankShort();
    int w;
    waitRise();
    tripIn = 1'b1;
    repeat (10) @(negedge clk);
    tripIn = 1'b0;
    w = 11;
    @(negedge clk);
    while (pwmDrive === 1'b1) begin w++; @(negedge clk); end
    check(w == W_LO, "R5 blanked trip ignored", w, W_LO);
  endtask

  task automatic t_tripHeld();
    int w, highs;
    waitRise();
    tripIn = 1'b1;
    measureWidth(w);
    check(w == BLANK + 1, "R5 held trip width", w, BLANK + 1);
    highs = 0;
    for (int i = 0; i < PER_LO + 20; i++) begin
      @(negedge clk);
      if (pwmDrive === 1'b1) highs++;
    end
    check(highs == 0, "R6 trip at start skips cycle", highs, 0);
    tripIn = 1'b0;
  endtask

  task automatic t_underVolt();
    int highs = 0;
    int w;
    waitRise();
    repeat (50) @(negedge clk);
    uvFlag = 1'b1;
    repeat (4) @(negedge clk);
    check(pwmDrive === 1'b0, "R9 uv forces low", int'(pwmDrive), 0);
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (pwmDrive === 1'b1) highs++;
    end
    check(highs == 0, "R9 low while uv", highs, 0);
    uvFlag = 1'b0;
    waitRise();
    measureWidth(w);
    check(w == W_LO, "R9 full pulse after uv", w, W_LO);
  endtask

  task automatic t_overTemp();
    otFlag = 1'b1;
    repeat (4) @(negedge clk);
    check(pwmOe === 1'b0, "R10 oe released", int'(pwmOe), 0);
    otFlag = 1'b0;
    repeat (4) @(negedge clk);
    check(pwmOe === 1'b1, "R10 oe restored", int'(pwmOe), 1);
  endtask

  task automatic t_freqHi();
    int w, p;
    freqSel = 1'b1;
    waitRise();
    waitRise();
    measureWidth(w);
    check(w == W_HI, "R4 high freq width", w, W_HI);
    p = w;
    do begin @(negedge clk); p++; end while (pwmDrive !== 1'b1);
    check(p == PER_HI, "R4 high period", p, PER_HI);
    freqSel = 1'b0;
    waitRise();
    waitRise();
  endtask

  task automatic t_enGlitch();
    int w;
    enIn = 1'b0;
    repeat (2000) @(negedge clk);
    enIn = 1'b1;
    check(ssReset === 1'b0, "R7 short low ignored", int'(ssReset), 0);
    waitRise();
    measureWidth(w);
    check(w == W_LO, "R7 switching continues", w, W_LO);
  endtask

  task automatic t_shutdown();
    int highs = 0;
    enIn = 1'b0;
    repeat (EN_OFF - 20) @(negedge clk);
    check(ssReset === 1'b0, "R7 running before delay", int'(ssReset), 0);
    repeat (40) @(negedge clk);
    check(ssReset === 1'b1, "R7 shutdown after delay", int'(ssReset), 1);
    for (int i = 0; i < 2 * PER_LO; i++) begin
      @(negedge clk);
      if (pwmDrive === 1'b1) highs++;
    end
    check(highs == 0, "R7 drive low in shutdown", highs, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    t_reset();
    t_startup();
    t_maxDuty();
    t_tripMid();
    t_blankShort();
    t_tripHeld();
    t_underVolt();
    t_overTemp();
    t_freqHi();
    t_enGlitch();
    t_shutdown();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule